// File: doc/BRIEF.md
# Segmented Scan Diagnosis Controller

This block holds one long scan chain cut into a number of equal sub-chains. Multiplexers between the sub-chains let a controller set the data source of every sub-chain and decide where its output goes. In normal operation the sub-chains are linked in index order, so the whole thing acts like one unbroken chain. A compacting signature register (MISR) can watch a single chosen sub-chain while the outputs of all the others are forced to zero. Comparing signatures taken one sub-chain at a time shows which segment is corrupting data.

Once a segment is known to be bad, for example because it has a hold-time violation, bypass mode takes that segment out of the shift path. The segments on either side of it are then wired straight together, so the rest of the chain can still be loaded and unloaded. The mode and the segment select are captured only in cycles where shift enable is low, so a configuration change never lands in the middle of a shift burst.

Top module: `segscan_diag_ctrl`

## Requirements
- R1: After synchronous reset, every scan cell holds 0, `scan_out` is 0, `signature` equals `MISR_SEED`, and the active configuration is normal mode with segment 0.
- R2: In normal mode (`mode_sel` = 0), segments are linked from segment 0 (fed by `scan_in`) to the last segment. Each segment shifts toward its cell 0, and cell 0 is the segment's output. `scan_out` is a register loaded from the chain end on each shift. A bit presented at `scan_in` therefore appears at `scan_out` after NUM_SEG*SEG_LEN+1 shift cycles.
- R3: While `shift_en` is low, no scan cell and no `scan_out` value changes, whatever `scan_in` does.
- R4: In observe mode (`mode_sel` = 1), on each shift the signature becomes (sig<<1) XOR (sig[MSB] ? `MISR_POLY` : 0) XOR v. Bit k of v is the output of segment k if k is the selected segment, and 0 otherwise. The chain keeps shifting as in normal mode.
- R5: In observe mode, the outputs of unselected segments have no effect on the signature.
- R6: In a cycle with `shift_en` low, the signature is loaded with `MISR_SEED` when the requested mode is observe and either the requested mode or the requested segment differs from the active one. Requesting the same observe configuration again leaves the signature unchanged.
- R7: In bypass mode (`mode_sel` = 2), the selected segment holds its contents and is skipped. Its upstream neighbour (or `scan_in`) feeds its downstream neighbour (or the `scan_out` register) directly, so latency becomes (NUM_SEG-1)*SEG_LEN+1.
- R8: The mode and segment select are captured only in cycles where `shift_en` is low. Changes made while `shift_en` is high have no effect.
- R9: In normal and bypass modes the signature holds its value.
- R10: The mode code 3 behaves exactly like normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Shift one position per cycle when high; configuration capture when low |
| mode_sel | input | 2 | Requested mode: 0 normal, 1 observe, 2 bypass, 3 normal |
| seg_sel | input | SEL_W | Requested segment index for observe or bypass |
| scan_in | input | 1 | Serial scan data into the chain |
| scan_out | output | 1 | Registered serial scan data out of the chain |
| signature | output | MISR_W | MISR signature |

## Verification
The hardest case to reach is showing that masked segments truly leak nothing into the signature, and that re-requesting the same observe setup does not reseed. Both need every segment to hold distinct, non-zero data while one segment is observed. The stimulus therefore fills the whole chain with random data in normal mode before switching to observe. It then tries a mode change in the middle of a burst, a repeated observe request and a new segment. Bypass runs on an interior segment and on the last segment are followed by a return to normal mode. This brings the held contents of the bypassed segment out at `scan_out`, where they can be compared.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_OBS  = 2'd1,
    MODE_BYP  = 2'd2
  } scan_mode_e;

  // Code 3 falls back to normal linking.
  function automatic scan_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    decode_mode = MODE_OBS;
      2'd2:    decode_mode = MODE_BYP;
      default: decode_mode = MODE_NORM;
    endcase
  endfunction

endpackage

// File: rtl/scan_segment.sv
module scan_segment #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);

  logic [LEN-1:0] cells;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)     cells <= '0;
        else if (en) cells <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)     cells <= '0;
        else if (en) cells <= {din, cells[LEN-1:1]};
      end
    end
  endgenerate

  assign dout = cells[0];

  // R7 / R3: a segment that is not enabled keeps its contents
  a_r7_seg_held: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cells));

endmodule

// File: rtl/chain_router.sv
module chain_router #(
  parameter int NSEG = 4,
  parameter int SELW = 2
) (
  input  logic            shift_en,
  input  logic            bypass,
  input  logic [SELW-1:0] sel,
  input  logic            scan_in,
  input  logic [NSEG-1:0] seg_out,
  output logic [NSEG-1:0] seg_in,
  output logic [NSEG-1:0] seg_en,
  output logic            chain_out
);

  always_comb begin
    logic carry;
    logic skip;
    carry = scan_in;
    for (int k = 0; k < NSEG; k++) begin
      skip      = bypass && (sel == SELW'(k));
      seg_in[k] = carry;
      seg_en[k] = shift_en && !skip;
      if (!skip) carry = seg_out[k];
    end
    chain_out = carry;
  end

endmodule

// File: rtl/sig_misr.sv
module sig_misr #(
  parameter int           W    = 16,
  parameter int           NIN  = 4,
  parameter logic [W-1:0] POLY = 16'h1021,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           seed_load,
  input  logic           upd,
  input  logic [NIN-1:0] din,
  output logic [W-1:0]   sig
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = {sig[W-2:0], 1'b0} ^ (sig[W-1] ? POLY : '0) ^ W'(din);
  end

  always_ff @(posedge clk) begin
    if (rst || seed_load) sig <= SEED;
    else if (upd)         sig <= nxt;
  end

  // R6: a session start reseeds the register
  a_r6_seed_load: assert property (@(posedge clk) disable iff (rst)
    seed_load |=> (sig == SEED));

  // R9: no update request means the signature holds
  a_r9_sig_idle: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !upd) |=> $stable(sig));

endmodule

// File: rtl/segscan_diag_ctrl.sv
module segscan_diag_ctrl
  import segscan_pkg::*;
#(
  parameter int                NUM_SEG   = 4,
  parameter int                SEG_LEN   = 8,
  parameter int                MISR_W    = 16,
  parameter logic [MISR_W-1:0] MISR_POLY = 16'h1021,
  parameter logic [MISR_W-1:0] MISR_SEED = 16'hACE1,
  localparam int               SEL_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [1:0]        mode_sel,
  input  logic [SEL_W-1:0]  seg_sel,
  input  logic              scan_in,
  output logic              scan_out,
  output logic [MISR_W-1:0] signature
);

  scan_mode_e       act_mode;
  logic [SEL_W-1:0] act_sel;
  scan_mode_e       req_mode;
  logic             seed_load;
  logic             misr_upd;
  logic [NUM_SEG-1:0] seg_in, seg_out, seg_en, obs_vec;
  logic             chain_out;

  assign req_mode = decode_mode(mode_sel);

  // Configuration capture only between shift bursts
  always_ff @(posedge clk) begin
    if (rst) begin
      act_mode <= MODE_NORM;
      act_sel  <= '0;
    end else if (!shift_en) begin
      act_mode <= req_mode;
      act_sel  <= seg_sel;
    end
  end

  assign seed_load = !shift_en && (req_mode == MODE_OBS) &&
                     ((req_mode != act_mode) || (seg_sel != act_sel));
  assign misr_upd  = shift_en && (act_mode == MODE_OBS);

  chain_router #(.NSEG(NUM_SEG), .SELW(SEL_W)) u_router (
    .shift_en (shift_en),
    .bypass   (act_mode == MODE_BYP),
    .sel      (act_sel),
    .scan_in  (scan_in),
    .seg_out  (seg_out),
    .seg_in   (seg_in),
    .seg_en   (seg_en),
    .chain_out(chain_out)
  );

  generate
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      scan_segment #(.LEN(SEG_LEN)) u_seg (
        .clk (clk),
        .rst (rst),
        .en  (seg_en[g]),
        .din (seg_in[g]),
        .dout(seg_out[g])
      );
      // Masking: only the observed segment reaches the compactor
      assign obs_vec[g] = seg_out[g] && (act_mode == MODE_OBS) &&
                          (act_sel == SEL_W'(g));
    end
  endgenerate

  sig_misr #(.W(MISR_W), .NIN(NUM_SEG), .POLY(MISR_POLY), .SEED(MISR_SEED)) u_misr (
    .clk      (clk),
    .rst      (rst),
    .seed_load(seed_load),
    .upd      (misr_upd),
    .din      (obs_vec),
    .sig      (signature)
  );

  always_ff @(posedge clk) begin
    if (rst)           scan_out <= 1'b0;
    else if (shift_en) scan_out <= chain_out;
  end

  // R8: active configuration never moves during a shift
  a_r8_cfg_stable: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ($stable(act_mode) && $stable(act_sel)));

  // R3: scan output frozen without shift
  a_r3_so_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(scan_out));

  // R5: at most one segment feeds the compactor
  a_r5_mask_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(obs_vec));

  // R9: bypass or normal mode never disturbs the signature while shifting
  a_r9_no_upd_outside_obs: assert property (@(posedge clk) disable iff (rst)
    (shift_en && act_mode != MODE_OBS) |=> $stable(signature));

endmodule

// File: tb/segscan_diag_ctrl_tb_top.sv
`timescale 1ns/1ps
module segscan_diag_ctrl_tb_top;

  localparam int          S    = 4;
  localparam int          L    = 8;
  localparam int          W    = 16;
  localparam logic [W-1:0] POLY = 16'h1021;
  localparam logic [W-1:0] SEED = 16'hACE1;

  logic         clk = 1'b0;
  logic         rst;
  logic         shift_en;
  logic [1:0]   mode_sel;
  logic [1:0]   seg_sel;
  logic         scan_in;
  logic         scan_out;
  logic [W-1:0] signature;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  segscan_diag_ctrl #(.NUM_SEG(S), .SEG_LEN(L), .MISR_W(W),
                      .MISR_POLY(POLY), .MISR_SEED(SEED)) dut_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .mode_sel(mode_sel),
    .seg_sel(seg_sel), .scan_in(scan_in), .scan_out(scan_out),
    .signature(signature)
  );

  // Reference model state
  logic [L-1:0] m_seg [S];
  int           m_mode;
  logic [1:0]   m_sel;
  logic         m_so;
  logic [W-1:0] m_sig;

  // Scoreboard queues
  logic         q_so  [$];
  logic [W-1:0] q_sig [$];
  string        q_tag [$];

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic se, input logic [1:0] md, input logic [1:0] sl, input logic si);
    int req;
    logic carry;
    logic [S-1:0] v;
    logic [L-1:0] nseg [S];
    req = (md == 2'd1) ? 1 : (md == 2'd2) ? 2 : 0;
    if (!se) begin
      if (req == 1 && (req != m_mode || sl != m_sel)) m_sig = SEED;
      m_mode = req;
      m_sel  = sl;
    end else begin
      carry = si;
      v = '0;
      if (m_mode == 1) v[m_sel] = m_seg[m_sel][0];
      for (int k = 0; k < S; k++) begin
        nseg[k] = m_seg[k];
        if (!(m_mode == 2 && m_sel == 2'(k))) begin
          nseg[k] = {carry, m_seg[k][L-1:1]};
          carry   = m_seg[k][0];
        end
      end
      for (int k = 0; k < S; k++) m_seg[k] = nseg[k];
      m_so = carry;
      if (m_mode == 1)
        m_sig = {m_sig[W-2:0], 1'b0} ^ (m_sig[W-1] ? POLY : '0) ^ W'(v);
    end
  endtask

  // Driver: apply one cycle, push the expected post-edge outputs
  task automatic cyc(input logic se, input logic [1:0] md, input logic [1:0] sl, input logic si, input string tag);
    @(negedge clk);
    shift_en = se; mode_sel = md; seg_sel = sl; scan_in = si;
    model_step(se, md, sl, si);
    @(posedge clk);
    #1;
    q_so.push_back(m_so);
    q_sig.push_back(m_sig);
    q_tag.push_back(tag);
  endtask

  task automatic burst(input int n, input logic [1:0] md, input logic [1:0] sl, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, md, sl, 1'($urandom), tag);
  endtask

  // Monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (q_so.size() > 0) begin
        string t;
        logic e_so;
        logic [W-1:0] e_sig;
        e_so = q_so.pop_front();
        e_sig = q_sig.pop_front();
        t = q_tag.pop_front();
        check(t, W'(scan_out), W'(e_so), "scan_out");
        check(t, signature, e_sig, "signature");
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; shift_en = 1'b0; mode_sel = 2'd0; seg_sel = 2'd0; scan_in = 1'b0;
    for (int k = 0; k < S; k++) m_seg[k] = '0;
    m_mode = 0; m_sel = 2'd0; m_so = 1'b0; m_sig = SEED;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", W'(scan_out), '0, "scan_out");
    check("R1", signature, SEED, "signature");
    cyc(1'b0, 2'd0, 2'd0, 1'b1, "R1");
    cyc(1'b0, 2'd0, 2'd0, 1'b0, "R3");
    // R2: normal fill and flush, latency covered by the model
    burst(40, 2'd0, 2'd0, "R2");
    // R3: holds with toggling scan_in
    for (int i = 0; i < 5; i++) cyc(1'b0, 2'd0, 2'd0, 1'(i), "R3");
    // R6 then R4: observe segment 2 with all segments loaded
    cyc(1'b0, 2'd1, 2'd2, 1'b0, "R6");
    burst(24, 2'd1, 2'd2, "R4");
    // R8: request bypass mid-burst; must be ignored
    burst(6, 2'd2, 2'd0, "R8");
    // R6: same observe request again does not reseed
    cyc(1'b0, 2'd1, 2'd2, 1'b1, "R6");
    cyc(1'b0, 2'd1, 2'd2, 1'b0, "R6");
    burst(4, 2'd1, 2'd2, "R4");
    // R6 then R5: new segment reseeds; others masked
    cyc(1'b0, 2'd1, 2'd0, 1'b0, "R6");
    burst(20, 2'd1, 2'd0, "R5");
    cyc(1'b0, 2'd1, 2'd3, 1'b0, "R6");
    burst(12, 2'd1, 2'd3, "R5");
    // R7 / R9: bypass segment 1; signature must hold
    cyc(1'b0, 2'd2, 2'd1, 1'b0, "R7");
    burst(40, 2'd2, 2'd1, "R7");
    burst(4, 2'd2, 2'd1, "R9");
    // Back to normal: held segment 1 content flushes out
    cyc(1'b0, 2'd0, 2'd0, 1'b0, "R2");
    burst(40, 2'd0, 2'd0, "R2");
    // R10: code 3 acts as normal
    cyc(1'b0, 2'd3, 2'd3, 1'b0, "R10");
    burst(36, 2'd3, 2'd3, "R10");
    // R7: bypass the last and first segments
    cyc(1'b0, 2'd2, 2'd3, 1'b0, "R7");
    burst(30, 2'd2, 2'd3, "R7");
    cyc(1'b0, 2'd2, 2'd0, 1'b0, "R7");
    burst(30, 2'd2, 2'd0, "R7");
    cyc(1'b0, 2'd0, 2'd0, 1'b0, "R2");
    burst(36, 2'd0, 2'd0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule